// File: doc/BRIEF.md
# Host Bus Width Sensing and Byte Lane Steering

This block sits between an ISA-style host bus and the data path of a removable card. It needs no configuration to learn how wide the host bus is. It comes out of reset treating the host as an 8-bit bus. The first time it samples the byte-high-enable input (active low) as asserted, it switches to 16-bit operation and stays there until the next reset. In 8-bit operation every byte moves on host lines 7:0, and the address bit 0 picks the even or the odd card byte. In 16-bit operation the pair (byte-high-enable, address bit 0) is decoded into one of four cases: a word, an odd byte on the upper lane, an even byte on the lower lane, or an invalid combination, which is ignored.

Every valid access on a 16-bit host asserts the matching 16-bit acknowledge, memory or I/O, for as long as the access is in flight, including when the card is only 8 bits wide. A host word aimed at an 8-bit card is carried out as two card byte accesses, even byte first. Host ready stays low until both have finished. On a read, the even byte is held and the two bytes are presented together on the host lanes. The card side uses a level request that is held until a one-cycle done pulse. All card byte data travels on card lines 7:0, with a separate odd-byte select.

Top module: `isa_lane_steer`

## Requirements
- R1: While reset is asserted and just after it is released: bus-width flag low, host ready high, card request low, both 16-bit acknowledges high (inactive), host read data zero.
- R2: The bus-width flag rises on the clock edge that samples byte-high-enable low and stays high until reset. An access whose request cycle sees byte-high-enable low is already decoded as 16-bit.
- R3: In 8-bit operation, a request makes one card byte access (card_wide=0) with card_odd equal to address bit 0. Write data is taken from host lines 7:0, read data is returned on host lines 7:0 with lines 15:8 zero, and neither acknowledge is asserted.
- R4: In 16-bit operation, byte-high-enable=0 and bit0=0 is a word. For a 16-bit card (card_is16=1) this is one card access with card_wide=1 and all 16 data bits passed both ways.
- R5: In 16-bit operation, byte-high-enable=0 and bit0=1 is one odd card byte (card_odd=1). Write data comes from host lines 15:8, and read data is returned on host lines 15:8 with lines 7:0 zero.
- R6: In 16-bit operation, byte-high-enable=1 and bit0=0 is one even card byte (card_odd=0). Write data comes from host lines 7:0, and read data is returned on lines 7:0 with lines 15:8 zero.
- R7: In 16-bit operation, byte-high-enable=1 and bit0=1 is ignored. There is no card request and no acknowledge, host ready stays high and host read data is unchanged.
- R8: During every valid 16-bit access, host_cs16_mem_n is low for memory cycles (host_io=0) and host_cs16_io_n is low for I/O cycles (host_io=1), from the cycle after the request until the access completes.
- R9: A word to an 8-bit card (card_is16=0) produces exactly two card byte accesses: first card_odd=0 with host bits 7:0, then card_odd=1 with host bits 15:8. Host ready stays low until the second one is done.
- R10: On such a split read, host read data becomes {second byte, first byte} when the second access completes.
- R11: Card request is held with stable controls until card_done. Host ready drops the cycle after a valid request and rises the cycle after the final card_done. Card byte data uses card lines 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle request strobe, honoured while host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| host_sbhe_n | input | 1 | Host byte-high-enable, active low |
| host_a0 | input | 1 | Host address bit 0 |
| host_wdata | input | 16 | Host write data, both lanes |
| host_rdata | output | 16 | Host read data, both lanes |
| host_ready | output | 1 | High when idle and ready for a request |
| host_cs16_mem_n | output | 1 | 16-bit acknowledge for memory cycles, active low |
| host_cs16_io_n | output | 1 | 16-bit acknowledge for I/O cycles, active low |
| bus16 | output | 1 | Learned bus width: 1 = 16-bit host |
| card_is16 | input | 1 | Card data path is 16 bits wide |
| card_req | output | 1 | Card access request, held until done |
| card_we | output | 1 | Card access direction |
| card_odd | output | 1 | Card byte select: 1 = odd byte |
| card_wide | output | 1 | Card access is a full word |
| card_wdata | output | 16 | Card write data (bytes on 7:0) |
| card_rdata | input | 16 | Card read data (bytes on 7:0) |
| card_done | input | 1 | One-cycle completion of the card access |

## Verification
The bench first targets the mode change itself. It runs a long stretch of traffic with byte-high-enable held high, where a detector that latched on noise or came out of reset wide would show a wide access or an acknowledge. It then checks that the first low sample flips the mode on that very request, and that only a reset clears it. Word accesses to a narrow card are checked for byte order, for the count of card cycles and for read assembly. A sequencer that released ready after the first byte, swapped the bytes or lost the held byte would return the wrong word. The invalid lane combination is issued with read data still holding an earlier value, so a decoder that treated it as a byte would start a card cycle or overwrite that value. The card model answers upper card lines with junk, so any steering that takes a byte from the wrong lane becomes visible.

// File: rtl/isa_lane_pkg.sv
package isa_lane_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FIRST  = 2'd1,
        SQ_SECOND = 2'd2
    } seq_e;

    typedef struct packed {
        logic valid;
        logic word;
        logic odd;
        logic upper;
        logic acc16;
    } lane_sel_t;

endpackage

// File: rtl/isa_width_sense.sv
module isa_width_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic sbhe_n,
    output logic wide_q,
    output logic wide_now
);
    logic wide_d;

    always_comb begin
        wide_d = wide_q | ~sbhe_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wide_q <= 1'b0;
        else        wide_q <= wide_d;
    end

    assign wide_now = wide_d;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wide_q |=> wide_q);
    assert_learn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sbhe_n |=> wide_q);
endmodule

// File: rtl/isa_lane_decode.sv
module isa_lane_decode
    import isa_lane_pkg::*;
(
    input  logic      wide_mode,
    input  logic      sbhe_n,
    input  logic      a0,
    output lane_sel_t sel
);
    always_comb begin
        sel = '0;
        if (!wide_mode) begin
            sel.valid = 1'b1;
            sel.odd   = a0;
        end else begin
            sel.acc16 = 1'b1;
            unique case ({sbhe_n, a0})
                2'b00: begin sel.valid = 1'b1; sel.word = 1'b1; end
                2'b01: begin sel.valid = 1'b1; sel.odd = 1'b1; sel.upper = 1'b1; end
                2'b10: begin sel.valid = 1'b1; end
                default: begin sel.valid = 1'b0; sel.acc16 = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/isa_split_seq.sv
module isa_split_seq
    import isa_lane_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                host_we,
    input  logic                host_io,
    input  logic [2*BYTE_W-1:0] host_wdata,
    input  lane_sel_t           sel,
    input  logic                card_is16,
    output logic [2*BYTE_W-1:0] host_rdata,
    output logic                host_ready,
    output logic                cs16_mem_n,
    output logic                cs16_io_n,
    output logic                card_req,
    output logic                card_we,
    output logic                card_odd,
    output logic                card_wide,
    output logic [2*BYTE_W-1:0] card_wdata,
    input  logic [2*BYTE_W-1:0] card_rdata,
    input  logic                card_done
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        seq_e              st;
        logic              we;
        logic              io;
        logic              acc16;
        logic              word;
        logic              split;
        logic              odd;
        logic              upper;
        logic [WORD_W-1:0] wdata;
        logic [BYTE_W-1:0] lo;
        logic [WORD_W-1:0] rdata;
    } seq_t;

    seq_t r_q, r_d;
    logic [BYTE_W-1:0] byte_out;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (host_req && sel.valid) begin
                    r_d.st    = SQ_FIRST;
                    r_d.we    = host_we;
                    r_d.io    = host_io;
                    r_d.acc16 = sel.acc16;
                    r_d.word  = sel.word;
                    r_d.split = sel.word & ~card_is16;
                    r_d.odd   = sel.odd;
                    r_d.upper = sel.upper;
                    r_d.wdata = host_wdata;
                end
            end
            SQ_FIRST: begin
                if (card_done) begin
                    if (r_q.split) begin
                        r_d.st = SQ_SECOND;
                        r_d.lo = card_rdata[BYTE_W-1:0];
                    end else begin
                        r_d.st = SQ_IDLE;
                        if (!r_q.we) begin
                            if (r_q.word)
                                r_d.rdata = card_rdata;
                            else if (r_q.upper)
                                r_d.rdata = {card_rdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
                            else
                                r_d.rdata = {{BYTE_W{1'b0}}, card_rdata[BYTE_W-1:0]};
                        end
                    end
                end
            end
            SQ_SECOND: begin
                if (card_done) begin
                    r_d.st = SQ_IDLE;
                    if (!r_q.we) r_d.rdata = {card_rdata[BYTE_W-1:0], r_q.lo};
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (r_q.st == SQ_SECOND || r_q.upper)
            byte_out = r_q.wdata[WORD_W-1:BYTE_W];
        else
            byte_out = r_q.wdata[BYTE_W-1:0];
    end

    assign host_ready = (r_q.st == SQ_IDLE);
    assign host_rdata = r_q.rdata;
    assign card_req   = (r_q.st != SQ_IDLE);
    assign card_we    = r_q.we;
    assign card_wide  = (r_q.st == SQ_FIRST) && r_q.word && !r_q.split;
    assign card_odd   = (r_q.st == SQ_SECOND) || ((r_q.st == SQ_FIRST) && r_q.odd);
    assign card_wdata = card_wide ? r_q.wdata : {{BYTE_W{1'b0}}, byte_out};
    assign cs16_mem_n = !(card_req && r_q.acc16 && !r_q.io);
    assign cs16_io_n  = !(card_req && r_q.acc16 && r_q.io);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_done |=> card_req && $stable(card_odd) && $stable(card_wide));
    assert_split_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_FIRST) && card_done && r_q.split |=> card_req && card_odd && !host_ready);
    assert_ready_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_SECOND) && card_done |=> host_ready);
    assert_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready && host_req && !sel.valid |=> host_ready && !card_req && $stable(host_rdata));
    assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs16_mem_n && !cs16_io_n));
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
    import isa_lane_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_io,
    input  logic              host_sbhe_n,
    input  logic              host_a0,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              host_cs16_mem_n,
    output logic              host_cs16_io_n,
    output logic              bus16,
    input  logic              card_is16,
    output logic              card_req,
    output logic              card_we,
    output logic              card_odd,
    output logic              card_wide,
    output logic [WORD_W-1:0] card_wdata,
    input  logic [WORD_W-1:0] card_rdata,
    input  logic              card_done
);
    logic      wide_now;
    lane_sel_t sel;

    isa_width_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbhe_n   (host_sbhe_n),
        .wide_q   (bus16),
        .wide_now (wide_now)
    );

    isa_lane_decode u_decode (
        .wide_mode (wide_now),
        .sbhe_n    (host_sbhe_n),
        .a0        (host_a0),
        .sel       (sel)
    );

    isa_split_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_io    (host_io),
        .host_wdata (host_wdata),
        .sel        (sel),
        .card_is16  (card_is16),
        .host_rdata (host_rdata),
        .host_ready (host_ready),
        .cs16_mem_n (host_cs16_mem_n),
        .cs16_io_n  (host_cs16_io_n),
        .card_req   (card_req),
        .card_we    (card_we),
        .card_odd   (card_odd),
        .card_wide  (card_wide),
        .card_wdata (card_wdata),
        .card_rdata (card_rdata),
        .card_done  (card_done)
    );

    assert_narrow_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !bus16 |-> !card_wide && host_cs16_mem_n && host_cs16_io_n);
    assert_byte_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_wide |-> card_wdata[WORD_W-1:BYTE_W] == '0);
endmodule

// File: tb/sim_isa_lane_steer.sv
module sim_isa_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_io = 1'b0;
    logic        host_sbhe_n = 1'b1, host_a0 = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ready, host_cs16_mem_n, host_cs16_io_n, bus16;
    logic        card_is16 = 1'b0;
    logic        card_req, card_we, card_odd, card_wide;
    logic [15:0] card_wdata;
    logic [15:0] card_rdata = '0;
    logic        card_done = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    bit mode16_exp = 0;
    logic [15:0] exp_rdata = '0;
    logic [7:0]  rd_even, rd_odd;
    logic [15:0] rd_word;
    int n_log = 0;
    int dly = 0;
    logic        log_odd [4];
    logic        log_wide[4];
    logic        log_we  [4];
    logic [15:0] log_wd  [4];

    always #5 clk = ~clk;

    isa_lane_steer u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // card model: random latency, junk on upper lines for byte accesses
    always @(negedge clk) begin
        if (card_done) begin
            card_done = 1'b0;
        end else if (card_req) begin
            if (dly == 0) begin
                card_done = 1'b1;
                if (card_wide) card_rdata = rd_word;
                else if (card_odd) card_rdata = {~rd_odd, rd_odd};
                else card_rdata = {~rd_even, rd_even};
                if (n_log < 4) begin
                    log_odd[n_log]  = card_odd;
                    log_wide[n_log] = card_wide;
                    log_we[n_log]   = card_we;
                    log_wd[n_log]   = card_wdata;
                end
                n_log++;
                dly = $urandom % 3;
            end else begin
                dly--;
            end
        end
    end

    task automatic do_txn(input bit sbhe, input bit a0, input bit io, input bit we,
                          input bit c16, input logic [15:0] wd);
        bit eff, valid, word, hi, split;
        int nexp, to;
        string rq;
        eff   = mode16_exp | !sbhe;
        valid = !(eff && sbhe && a0);
        word  = eff && !sbhe && !a0;
        hi    = eff && !sbhe && a0;
        split = word && !c16;
        nexp  = split ? 2 : 1;
        rq    = !eff ? "R3" : (word ? (c16 ? "R4" : "R9") : (hi ? "R5" : "R6"));
        rd_even = 8'($urandom); rd_odd = 8'($urandom); rd_word = 16'($urandom);
        @(negedge clk);
        host_sbhe_n = sbhe; host_a0 = a0; host_io = io; host_we = we;
        card_is16 = c16; host_wdata = wd; host_req = 1'b1; n_log = 0;
        if (!sbhe) mode16_exp = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        chk(bus16 == mode16_exp, "R2", "bus16", 32'(bus16), 32'(mode16_exp));
        if (!valid) begin
            for (int i = 0; i < 3; i++) begin
                chk(card_req == 1'b0 && host_ready == 1'b1, "R7", "req/ready",
                    {card_req, host_ready}, 2'b01);
                chk(host_cs16_mem_n && host_cs16_io_n, "R7", "acks",
                    {host_cs16_mem_n, host_cs16_io_n}, 2'b11);
                @(negedge clk);
            end
            chk(host_rdata == exp_rdata, "R7", "rdata kept", 32'(host_rdata), 32'(exp_rdata));
            host_sbhe_n = 1'b1;
            return;
        end
        chk(host_ready == 1'b0, "R11", "ready low", 32'(host_ready), 0);
        chk(host_cs16_mem_n == !(eff && !io), "R8", "mem ack",
            32'(host_cs16_mem_n), 32'(!(eff && !io)));
        chk(host_cs16_io_n == !(eff && io), "R8", "io ack",
            32'(host_cs16_io_n), 32'(!(eff && io)));
        to = 0;
        while (!host_ready && to < 100) begin
            @(negedge clk);
            to++;
            if (!host_ready && split && n_log == 1)
                chk(host_ready == 1'b0, "R9", "ready between bytes", 32'(host_ready), 0);
        end
        chk(to < 100, "R11", "completion", 32'(to), 100);
        chk(n_log == nexp, rq, "card access count", 32'(n_log), 32'(nexp));
        if (n_log >= 1) begin
            chk(log_we[0] == we, rq, "card we", 32'(log_we[0]), 32'(we));
            if (word && c16) begin
                chk(log_wide[0] == 1'b1, "R4", "wide", 32'(log_wide[0]), 1);
                chk(log_wd[0] == wd, "R4", "wdata", 32'(log_wd[0]), 32'(wd));
            end else begin
                chk(log_wide[0] == 1'b0, rq, "byte access", 32'(log_wide[0]), 0);
                chk(log_odd[0] == (!eff ? a0 : hi), rq, "odd select",
                    32'(log_odd[0]), 32'(!eff ? a0 : hi));
                chk(log_wd[0] == {8'h00, hi ? wd[15:8] : wd[7:0]}, rq, "byte wdata",
                    32'(log_wd[0]), 32'({8'h00, hi ? wd[15:8] : wd[7:0]}));
            end
        end
        if (split && n_log >= 2) begin
            chk(log_odd[1] == 1'b1 && log_wide[1] == 1'b0, "R9", "second odd byte",
                {log_odd[1], log_wide[1]}, 2'b10);
            chk(log_wd[1] == {8'h00, wd[15:8]}, "R9", "second wdata",
                32'(log_wd[1]), 32'({8'h00, wd[15:8]}));
        end
        if (!we) begin
            if (!eff) exp_rdata = {8'h00, a0 ? rd_odd : rd_even};
            else if (word) exp_rdata = c16 ? rd_word : {rd_odd, rd_even};
            else if (hi) exp_rdata = {rd_odd, 8'h00};
            else exp_rdata = {8'h00, rd_even};
            chk(host_rdata == exp_rdata, split ? "R10" : rq, "rdata",
                32'(host_rdata), 32'(exp_rdata));
        end else begin
            chk(host_rdata == exp_rdata, rq, "rdata unchanged by write",
                32'(host_rdata), 32'(exp_rdata));
        end
        chk(host_cs16_mem_n && host_cs16_io_n, "R8", "acks released",
            {host_cs16_mem_n, host_cs16_io_n}, 2'b11);
        host_sbhe_n = 1'b1;
    endtask

    task automatic reset_check;
        chk(bus16 == 1'b0, "R1", "bus16", 32'(bus16), 0);
        chk(host_ready == 1'b1, "R1", "ready", 32'(host_ready), 1);
        chk(card_req == 1'b0, "R1", "card_req", 32'(card_req), 0);
        chk(host_cs16_mem_n && host_cs16_io_n, "R1", "acks",
            {host_cs16_mem_n, host_cs16_io_n}, 2'b11);
        chk(host_rdata == 16'h0, "R1", "rdata", 32'(host_rdata), 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        @(negedge clk);
        reset_check();
        // 8-bit host traffic (R3)
        for (int i = 0; i < 40; i++)
            do_txn(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        chk(bus16 == 1'b0, "R2", "no learning while high", 32'(bus16), 0);
        // directed: first low sample is a split word read to an 8-bit card (R2, R9, R10)
        do_txn(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        do_txn(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hBEEF);
        do_txn(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1234);  // invalid (R7)
        do_txn(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);  // high byte (R5)
        do_txn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA55A);  // low byte (R6)
        do_txn(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);  // word, 16-bit card (R4)
        for (int i = 0; i < 150; i++)
            do_txn(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 16'($urandom));
        // reset clears learned width (R2)
        @(negedge clk);
        rst_n = 1'b0;
        mode16_exp = 1'b0;
        exp_rdata = '0;
        @(negedge clk);
        @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        do_txn(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
        chk(bus16 == 1'b0, "R2", "cleared by reset", 32'(bus16), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule